// File: doc/BRIEF.md
# Continuous-Phase Fast FSK Modulator

This block turns a serial bit stream into a stream of signed 8-bit sine samples whose frequency switches between a mark tone and a space tone. The phase stays continuous from one bit to the next. The block is fed a master-clock enable tick. It divides that tick down to a sample step, and then divides the step into bit periods. A bit clock is driven out at the bit rate. The transmit bit, the preamble request and all mode selects are captured on the step that raises this bit clock. The samples go to an external DAC or digital filter, which pulls a new value on each sample strobe.

Two select inputs choose the operating point. One says whether the master clock is the fast one (7.3728 MHz) or the slow one (3.6864 MHz). The other chooses the higher or lower of the two bit rates available for that clock. Together they give three bit rates: 2400, 1200 and 600 bps, each with its own mark and space pair. A preamble request replaces the user data with an alternating pattern that starts with 0. A phase-mode input picks where the carrier starts: at 0 degrees (sine form) or at 90 degrees (cosine form).

Top module: `ffsk_modulator`

## Requirements
- R1: While reset is held and until the first sample step after it, `bit_clk` is 0, `sample_stb` is 0 and `sample_out` is 0.
- R2: One sample step happens for every `TICK_DIV` (3) cycles that have `mclk_en` high. `sample_stb` is high for one cycle right after each step. With `mclk_en` low there is no step and `sample_out` holds its value.
- R3: A bit lasts `2^STEP_LOG2` steps when `high_rate_sel` is 1 and twice that when it is 0. With `STEP_LOG2` = 10 this gives the true rates: fast/high 2400 bps, fast/low and slow/high 1200 bps, slow/low 600 bps.
- R4: `bit_clk` rises on the step that begins a bit and stays high for exactly half of that bit's steps.
- R5: The phase advance per bit, in carrier cycles, is mark/space = 0.5/1 at 2400 bps and 1/1.5 at 1200 and 600 bps. This gives tones of 1200/2400 Hz, 1200/1800 Hz and 600/900 Hz.
- R6: A transmit bit of 1 sends the mark tone and a 0 sends the space tone. The bit is captured on the step that raises `bit_clk`.
- R7: While `preamble_en` is high at a bit start, `tx_bit` has no effect. The bits sent are 0,1,0,1,… and the sequence starts again at 0 each time the preamble is entered anew.
- R8: If the phase mode is unchanged at a bit start, the phase carries on from the previous bit without a jump.
- R9: At the first bit start after reset, and at any bit start where `cos_mode` differs from the previous bit, the phase reloads. It reloads to 0 (sample 0) for `cos_mode` = 0 and to a quarter cycle (sample +127) for `cos_mode` = 1.
- R10: `sample_out` is two's complement and equals round(127·sin(2π·φ)), where φ is the phase truncated to 256 positions per cycle. The value -128 never appears.
- R11: A change of `fast_clk_sel`, `high_rate_sel`, `cos_mode`, `preamble_en` or `tx_bit` in the middle of a bit leaves the current bit's length and tone unchanged. The change applies from the next bit start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_en | input | 1 | One-cycle tick at the master-clock rate |
| fast_clk_sel | input | 1 | 1: 7.3728 MHz master, 0: 3.6864 MHz master |
| high_rate_sel | input | 1 | 1: higher bit rate of the pair, 0: lower |
| cos_mode | input | 1 | 0: sine-phase start, 1: cosine-phase start |
| preamble_en | input | 1 | Send alternating preamble instead of data |
| tx_bit | input | 1 | Serial transmit data |
| bit_clk | output | 1 | Bit-rate clock; rising edge marks bit capture |
| sample_stb | output | 1 | Pulses when a new sample is present |
| sample_out | output | 8 | Signed sine sample |

## Verification
The assertions assume that `mclk_en` is a plain per-cycle qualifier that may take any pattern. They also assume that reset is held for at least one clock, so that the post-reset history of phase, increment and bit clock starts from known values. The stimulus changes data and selects only while `bit_clk` is low, in the middle of a bit. This keeps every captured value unambiguous, and it also puts the mid-bit changes of R11 on exactly the cycles where the increment and bit-length holds are checked. A reference phase model checks the tone, the phase continuity and the length of every bit, with a tolerance that covers the 256-position phase truncation.

// File: rtl/ffsk_pkg.sv
// Shared types for the fast FSK modulator.
// Assumes: the two select inputs are combined into one rate code.
package ffsk_pkg;

    // Operating point, encoded as {fast master clock, high rate}.
    typedef enum logic [1:0] {
        RATE_SLOW_LO = 2'b00,
        RATE_SLOW_HI = 2'b01,
        RATE_FAST_LO = 2'b10,
        RATE_FAST_HI = 2'b11
    } rate_e;

    // Settings captured at a bit start.
    typedef struct packed {
        rate_e rate;
        logic  cos_mode;
    } bit_cfg_t;

    // Builds the rate code from the two select pins.
    function automatic rate_e rate_of(input logic fast, input logic high);
        return rate_e'({fast, high});
    endfunction

    // True when the rate code selects a double-length bit.
    function automatic logic is_long(input rate_e r);
        return (r == RATE_SLOW_LO) || (r == RATE_FAST_LO);
    endfunction

endpackage

// File: rtl/ffsk_bit_timer.sv
// Step and bit timing.
// Divides mclk_en ticks by TICK_DIV to make sample steps, then counts steps
// into bits of 2^STEP_LOG2 steps (2^(STEP_LOG2+1) when long_bit is set).
// Assumes: long_bit is the current bit's length flag and changes only at a
// boundary. The first step after reset is always a boundary.
module ffsk_bit_timer #(
    parameter int TICK_DIV  = 3,
    parameter int STEP_LOG2 = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_en,
    input  logic long_bit,
    output logic step,
    output logic boundary,
    output logic bit_clk
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int CW = STEP_LOG2 + 1;
    localparam logic [TW-1:0] TICK_LAST  = TW'(TICK_DIV - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'((1 << STEP_LOG2) - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'((2 << STEP_LOG2) - 1);
    localparam logic [CW-1:0] SHORT_HALF = CW'(1 << (STEP_LOG2 - 1));
    localparam logic [CW-1:0] LONG_HALF  = CW'(1 << STEP_LOG2);

    logic [TW-1:0] tick_cnt;
    logic [CW-1:0] step_cnt;
    logic [CW-1:0] step_cnt_inc;
    logic          first_q;
    logic [CW-1:0] last_idx;
    logic [CW-1:0] half_len;

    // Selects the last index and the half-length of the current bit.
    always_comb begin
        last_idx     = long_bit ? LONG_LAST : SHORT_LAST;
        half_len     = long_bit ? LONG_HALF : SHORT_HALF;
        step_cnt_inc = step_cnt + CW'(1);
    end

    assign step     = mclk_en && (tick_cnt == TICK_LAST);
    assign boundary = step && (first_q || (step_cnt == last_idx));

    // Counts master ticks within one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (mclk_en) begin
            tick_cnt <= (tick_cnt == TICK_LAST) ? '0 : tick_cnt + TW'(1);
        end
    end

    // Counts steps within one bit; the boundary step is index 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_cnt <= '0;
            first_q  <= 1'b1;
        end else if (step) begin
            step_cnt <= boundary ? '0 : step_cnt_inc;
            first_q  <= 1'b0;
        end
    end

    // Drives the bit clock high for the first half of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_clk <= 1'b0;
        end else if (step) begin
            bit_clk <= boundary ? 1'b1 : (step_cnt_inc < half_len);
        end
    end

endmodule

// File: rtl/ffsk_bit_select.sv
// Bit capture and tone selection.
// At each boundary this captures the transmit or preamble bit and the mode
// selects, then registers the phase increment the coming bit will use.
// It also flags when the phase must reload (first bit, or a phase-mode change).
// Assumes: boundary is a one-cycle strobe that coincides with a step.
module ffsk_bit_select
    import ffsk_pkg::*;
#(
    parameter int PHASE_W   = 24,
    parameter int STEP_LOG2 = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boundary,
    input  logic               tx_bit,
    input  logic               preamble_en,
    input  logic               fast_sel,
    input  logic               high_sel,
    input  logic               cos_sel,
    output logic               long_bit,
    output logic [PHASE_W-1:0] inc_q,
    output logic               reload,
    output logic [PHASE_W-1:0] start_phase
);
    // Half a carrier cycle spread over a short bit, and its multiples.
    localparam logic [PHASE_W-1:0] INC_H   = PHASE_W'(1) << (PHASE_W - 1 - STEP_LOG2);
    localparam logic [PHASE_W-1:0] INC_2H  = INC_H << 1;
    localparam logic [PHASE_W-1:0] INC_3H  = INC_H + INC_2H;
    localparam logic [PHASE_W-1:0] INC_15H = PHASE_W'(3) << (PHASE_W - 2 - STEP_LOG2);
    localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(1) << (PHASE_W - 2);

    bit_cfg_t           cfg_q;
    logic               pre_tog_q;
    logic               primed_q;
    logic               bit_now;
    rate_e              rate_now;
    logic [PHASE_W-1:0] inc_next;

    // Picks the bit to send and the increment for its tone.
    always_comb begin
        bit_now  = preamble_en ? pre_tog_q : tx_bit;
        rate_now = rate_of(fast_sel, high_sel);
        unique case (rate_now)
            RATE_FAST_HI: inc_next = bit_now ? INC_H  : INC_2H;
            RATE_FAST_LO: inc_next = bit_now ? INC_H  : INC_15H;
            RATE_SLOW_HI: inc_next = bit_now ? INC_2H : INC_3H;
            default:      inc_next = bit_now ? INC_H  : INC_15H;
        endcase
    end

    assign reload      = boundary && (!primed_q || (cos_sel != cfg_q.cos_mode));
    assign start_phase = cos_sel ? QUARTER : '0;
    assign long_bit    = is_long(cfg_q.rate);

    // Captures the settings and increment of the coming bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '{rate: RATE_SLOW_LO, cos_mode: 1'b0};
            pre_tog_q <= 1'b0;
            primed_q  <= 1'b0;
            inc_q     <= '0;
        end else if (boundary) begin
            cfg_q     <= '{rate: rate_now, cos_mode: cos_sel};
            pre_tog_q <= preamble_en & ~pre_tog_q;
            primed_q  <= 1'b1;
            inc_q     <= inc_next;
        end
    end

endmodule

// File: rtl/ffsk_nco.sv
// Phase accumulator.
// Advances by the current increment on every step, or loads a start phase
// when a reload is requested.
// Assumes: reload is only raised together with step.
module ffsk_nco #(
    parameter int PHASE_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic               reload,
    input  logic [PHASE_W-1:0] start_phase,
    input  logic [PHASE_W-1:0] inc,
    output logic [PHASE_W-1:0] phase_q
);
    // Holds the wrapping carrier phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (step) begin
            phase_q <= reload ? start_phase : phase_q + inc;
        end
    end

endmodule

// File: rtl/ffsk_sine_lut.sv
// Quarter-wave sine lookup.
// Maps the top bits of the phase to a signed sample. The table holds
// 2^LUT_LOG2 + 1 magnitudes from 0 to 90 degrees inclusive, computed at
// elaboration, so no quadrant needs an offset.
// Assumes: PHASE_W >= LUT_LOG2 + 2.
module ffsk_sine_lut #(
    parameter int PHASE_W  = 24,
    parameter int SAMPLE_W = 8,
    parameter int LUT_LOG2 = 6
) (
    input  logic [PHASE_W-1:0]         phase,
    output logic signed [SAMPLE_W-1:0] sample
);
    localparam int QN  = 1 << LUT_LOG2;
    localparam int MW  = SAMPLE_W - 1;
    localparam int AMP = (1 << (SAMPLE_W - 1)) - 1;
    localparam int IW  = LUT_LOG2 + 1;

    // Rounded magnitude of sin at i/QN of a quarter cycle (series expansion).
    function automatic int quarter_sine(input int i);
        real x;
        real term;
        real acc;
        x    = 3.14159265358979 * real'(i) / (2.0 * real'(QN));
        term = x;
        acc  = x;
        for (int k = 1; k <= 7; k++) begin
            term = -term * x * x / real'((2 * k) * (2 * k + 1));
            acc  = acc + term;
        end
        return $rtoi(acc * real'(AMP) + 0.5);
    endfunction

    logic [MW-1:0] mag_tab [QN+1];

    for (genvar g = 0; g <= QN; g++) begin : g_tab
        assign mag_tab[g] = MW'(quarter_sine(g));
    end

    logic [1:0]          quad;
    logic [LUT_LOG2-1:0] idx;
    logic [IW-1:0]       sel_idx;
    logic [MW-1:0]       mag;

    // Folds the phase into one quadrant and restores the sign.
    always_comb begin
        quad    = phase[PHASE_W-1 -: 2];
        idx     = phase[PHASE_W-3 -: LUT_LOG2];
        sel_idx = quad[0] ? (IW'(QN) - {1'b0, idx}) : {1'b0, idx};
        mag     = mag_tab[sel_idx];
        sample  = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

endmodule

// File: rtl/ffsk_modulator.sv
// Continuous-phase fast FSK modulator, top level.
// Puts the timer, the bit selector, the NCO and the sine lookup together.
// The sample and the bit clock change on the same edge, and sample_stb
// marks each new value.
// Assumes: mclk_en ticks at the master clock rate picked by fast_clk_sel.
module ffsk_modulator #(
    parameter int PHASE_W   = 24,
    parameter int SAMPLE_W  = 8,
    parameter int LUT_LOG2  = 6,
    parameter int TICK_DIV  = 3,
    parameter int STEP_LOG2 = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mclk_en,
    input  logic                       fast_clk_sel,
    input  logic                       high_rate_sel,
    input  logic                       cos_mode,
    input  logic                       preamble_en,
    input  logic                       tx_bit,
    output logic                       bit_clk,
    output logic                       sample_stb,
    output logic signed [SAMPLE_W-1:0] sample_out
);
    logic               step;
    logic               boundary;
    logic               long_bit;
    logic               reload;
    logic [PHASE_W-1:0] inc_q;
    logic [PHASE_W-1:0] start_phase;
    logic [PHASE_W-1:0] phase_q;
    logic               stb_q;

    ffsk_bit_timer #(.TICK_DIV(TICK_DIV), .STEP_LOG2(STEP_LOG2)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .mclk_en  (mclk_en),
        .long_bit (long_bit),
        .step     (step),
        .boundary (boundary),
        .bit_clk  (bit_clk)
    );

    ffsk_bit_select #(.PHASE_W(PHASE_W), .STEP_LOG2(STEP_LOG2)) u_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .boundary    (boundary),
        .tx_bit      (tx_bit),
        .preamble_en (preamble_en),
        .fast_sel    (fast_clk_sel),
        .high_sel    (high_rate_sel),
        .cos_sel     (cos_mode),
        .long_bit    (long_bit),
        .inc_q       (inc_q),
        .reload      (reload),
        .start_phase (start_phase)
    );

    ffsk_nco #(.PHASE_W(PHASE_W)) u_nco (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (step),
        .reload      (reload),
        .start_phase (start_phase),
        .inc         (inc_q),
        .phase_q     (phase_q)
    );

    ffsk_sine_lut #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W), .LUT_LOG2(LUT_LOG2)) u_lut (
        .phase  (phase_q),
        .sample (sample_out)
    );

    // Flags the cycle in which a fresh sample is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
        end else begin
            stb_q <= step;
        end
    end

    assign sample_stb = stb_q;

endmodule

// File: rtl/ffsk_modulator_chk.sv
// Property checker for ffsk_modulator, attached by bind.
// Assumes: reset is held for at least one clock before checking starts.
module ffsk_modulator_chk #(
    parameter int PHASE_W  = 24,
    parameter int SAMPLE_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       mclk_en,
    input logic                       sample_stb,
    input logic                       bit_clk,
    input logic signed [SAMPLE_W-1:0] sample_out,
    input logic                       step,
    input logic                       boundary,
    input logic                       reload,
    input logic [PHASE_W-1:0]         start_phase,
    input logic [PHASE_W-1:0]         phase_q,
    input logic [PHASE_W-1:0]         inc_q
);
    localparam logic signed [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

    // R2: a strobe always follows a master tick.
    assert_stb_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> $past(mclk_en));

    // R2: the sample only moves together with a strobe.
    assert_sample_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |-> $stable(sample_out));

    // R4: the bit clock only toggles on a sample step.
    assert_bitclk_on_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_clk != $past(bit_clk)) |-> sample_stb);

    // R9: a reload lands exactly on the requested start phase.
    assert_reload_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && reload) |=> (phase_q == $past(start_phase)));

    // R11: the increment only changes at a bit start.
    assert_inc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(inc_q));

    // R5: every step inside a bit advances the phase.
    assert_inc_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !boundary) |-> (inc_q != '0));

    // R10: the sample stays inside the symmetric range.
    assert_no_most_neg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sample_out != MOST_NEG);

endmodule

bind ffsk_modulator ffsk_modulator_chk #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mclk_en     (mclk_en),
    .sample_stb  (sample_stb),
    .bit_clk     (bit_clk),
    .sample_out  (sample_out),
    .step        (step),
    .boundary    (boundary),
    .reload      (reload),
    .start_phase (start_phase),
    .phase_q     (phase_q),
    .inc_q       (inc_q)
);

// File: tb/ffsk_modulator_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walked by one loop, then directed tests.
module ffsk_modulator_tb;
    localparam int LG = 6;          // shortened bit: 64 / 128 steps
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    always #10 clk = ~clk;          // 50 MHz

    logic rst_n = 1'b0, mclk_en = 1'b1, fast = 1'b1, high = 1'b1;
    logic cosm = 1'b0, pre = 1'b0, txb = 1'b0;
    logic bit_clk, sample_stb;
    logic signed [7:0] sample_out;

    ffsk_modulator #(.STEP_LOG2(LG)) u_dut (
        .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .fast_clk_sel(fast),
        .high_rate_sel(high), .cos_mode(cosm), .preamble_en(pre), .tx_bit(txb),
        .bit_clk(bit_clk), .sample_stb(sample_stb), .sample_out(sample_out));

    typedef struct packed {
        logic       f; logic h; logic c; logic p;
        logic [7:0] pat;
        logic [3:0] nbits;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'b01001101, 4'd6},
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'b00010110, 4'd5},
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'b00011010, 4'd5},
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'b00000110, 4'd4},
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'b00011001, 4'd5},
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'b00001001, 4'd4},
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'b00111111, 4'd6},
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'b00011111, 4'd5},
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'b11111111, 4'd4},
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'b00000000, 4'd4}
    };

    int checks = 0, fails = 0, cyc = 0;
    bit done = 1'b0;

    // reference model state
    real ph = 0.0, inc_cur = 0.0;
    int  steps_in_bit = 0, exp_n = 0, hi_steps = 0, last_hi = 0, last_len = 0;
    int  samp_bad = 0, len_bad = 0;
    bit  primed = 1'b0, cos_prev = 1'b0, pre_tog = 1'b0, prev_bc = 1'b0;
    bit  rose_ev = 1'b0, fell_ev = 1'b0, stb_ev = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int bitrate(input bit f, input bit h);
        if (f && h) return 2400;
        if (!f && !h) return 600;
        return 1200;
    endfunction

    function automatic real tone(input int br, input bit b);
        if (b) return (br == 600) ? 600.0 : 1200.0;
        if (br == 2400) return 2400.0;
        if (br == 1200) return 1800.0;
        return 900.0;
    endfunction

    // Reference phase model, updated once per strobe from the held inputs.
    task automatic observe();
        real expv, diff;
        int  br;
        bit  b;
        rose_ev = 1'b0; fell_ev = 1'b0; stb_ev = 1'b0;
        if (sample_stb) begin
            stb_ev = 1'b1;
            if (bit_clk && !prev_bc) begin
                rose_ev = 1'b1;
                last_len = steps_in_bit;
                if (primed && steps_in_bit != exp_n) len_bad++;
                if (!primed || (cosm != cos_prev)) ph = cosm ? 0.25 : 0.0;
                else ph = ph + inc_cur;
                b = pre ? pre_tog : txb;
                pre_tog = pre ? !pre_tog : 1'b0;
                br = bitrate(fast, high);
                exp_n = ((fast ? 7372800 : 3686400) / 3 / br) >>> (10 - LG);
                inc_cur = tone(br, b) / real'(br) / real'(exp_n);
                steps_in_bit = 1; hi_steps = 1;
                primed = 1'b1; cos_prev = cosm;
            end else begin
                ph = ph + inc_cur;
                steps_in_bit++;
                if (bit_clk) hi_steps++;
            end
            if (!bit_clk && prev_bc) begin
                fell_ev = 1'b1;
                last_hi = hi_steps;
            end
            if (ph >= 1.0) ph = ph - 1.0;
            expv = 127.0 * $sin(6.283185307179586 * ph);
            diff = real'(sample_out) - expv;
            if (diff > 4.0 || diff < -4.0) samp_bad++;
            prev_bc = bit_clk;
        end
    endtask

    task automatic tick();
        @(negedge clk);
        observe();
    endtask

    task automatic wait_rise();
        do tick(); while (!rose_ev);
    endtask

    task automatic wait_fall();
        do tick(); while (!fell_ev);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(bit_clk == 1'b0 && sample_stb == 1'b0 && sample_out == 0, "R1",
            int'(sample_out), 0);
        ph = 0.0; primed = 1'b0; pre_tog = 1'b0; prev_bc = 1'b0;
        steps_in_bit = 0; samp_bad = 0; len_bad = 0;
        rst_n = 1'b1;
    endtask

    // Watchdog: a hang counts as a failed check and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int gap, nstb;
        logic signed [7:0] held;

        // R1 reset state, then R9 sine start and R4 first rise
        do_reset();
        do tick(); while (!stb_ev);
        chk(sample_out == 0, "R9 sine start", int'(sample_out), 0);
        chk(bit_clk == 1'b1, "R4 first rise", int'(bit_clk), 1);

        // R2 step spacing with a steady tick
        gap = 0;
        do begin tick(); gap++; end while (!stb_ev);
        chk(gap == 3, "R2 step spacing", gap, 3);

        // R2 no step and a held sample while mclk_en is low
        mclk_en = 1'b0; nstb = 0; held = sample_out;
        repeat (3) tick();
        for (int i = 0; i < 40; i++) begin
            tick();
            if (sample_stb || sample_out != held) nstb++;
        end
        chk(nstb == 0, "R2 gated tick", nstb, 0);
        mclk_en = 1'b1;

        // Vector table: R3 R4 R5 R6 R7 R8 R9 R10 R11
        for (int v = 0; v < 10; v++) begin
            wait_fall();
            fast = VECS[v].f; high = VECS[v].h; cosm = VECS[v].c; pre = VECS[v].p;
            txb = VECS[v].pat[0];
            samp_bad = 0; len_bad = 0;
            for (int k = 0; k < int'(VECS[v].nbits); k++) begin
                wait_rise();
                wait_fall();
                txb = VECS[v].pat[k + 1];
            end
            chk(samp_bad == 0, "R5 R6 R7 R8 R10 samples", samp_bad, 0);
            chk(len_bad == 0, "R3 bit length", len_bad, 0);
            chk(last_hi == exp_n / 2, "R4 high half", last_hi, exp_n / 2);
        end

        // R11: a rate change mid-bit leaves the current bit unchanged
        pre = 1'b0; cosm = 1'b0;
        fast = 1'b1; high = 1'b1;
        wait_rise(); wait_fall();
        high = 1'b0;
        wait_rise();
        chk(last_len == 64, "R11 current bit kept", last_len, 64);
        wait_rise();
        chk(last_len == 128, "R11 next bit changed", last_len, 128);

        // R9 cosine start after reset
        cosm = 1'b1;
        wait_fall();
        do_reset();
        do tick(); while (!stb_ev);
        chk(sample_out == 127, "R9 cosine start", int'(sample_out), 127);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule